// File: doc/BRIEF.md
# Low-Power Stop Sequencer

This block controls how a small processor enters and leaves its low-power stop state. When the CPU executes its stop operation it raises a one-cycle stop request. The sequencer then drops the enables of the double-rate and quadruple-rate bus clocks, which halts the CPU and the peripherals, and holds its recovery counter cleared. A configuration bit can keep the quadruple-rate enable high during stop, so that an auto-wakeup timer keeps running.

A wake event ends the stop. It can be any of several module interrupt lines or a break request. The counter is then released and times a recovery delay on a free-running reference clock. The delay is 4096 reference cycles by default, or 32 when the short-recovery bit was set at stop entry. When the delay has fully elapsed, the bus clock enables return and a one-cycle strobe tells the CPU that it may begin interrupt stacking. The block reset forces it back to normal running from any state and takes priority over every wake source. Both configuration bits are captured when stop is entered and hold until recovery completes.

Top module: `stop_seq_ctrl`

## Requirements
- R1: After reset the mode output reads RUN (encoding 2'b00), bus2x_en and bus4x_en are high and stack_go is low.
- R2: A stop_req sampled high in RUN moves the block to STOPPED (2'b01) at the next clock edge. From that cycle on, bus2x_en is low, and bus4x_en is low unless the keep-fast bit was captured set.
- R3: In STOPPED the block stays put and the recovery counter stays cleared for as long as no wake event arrives. The recovery that follows is therefore full length, however long the stop lasted.
- R4: Any wake_irq bit high, or wake_brk high, sampled in STOPPED moves the block to RECOVERY (2'b10) at the next edge.
- R5: RECOVERY lasts exactly 4096 reference cycles when the captured short-recovery bit is clear and exactly 32 when it is set. bus2x_en stays low throughout.
- R6: The first cycle back in RUN after recovery has both enables high and stack_go high. stack_go is a single-cycle pulse and is never high at any other time.
- R7: With the keep-fast bit captured set, bus4x_en stays high through STOPPED and RECOVERY while bus2x_en stays low.
- R8: Driving rst_n low in any state sets RUN, both enables high and stack_go low at once, without waiting for a clock edge. This holds even when wake inputs are active.
- R9: cfg_short_rec and cfg_keep_fast are sampled only on the stop-entry edge. Changing them during STOPPED or RECOVERY changes neither bus4x_en nor the recovery length.
- R10: Wake events during RECOVERY are ignored. They neither restart nor lengthen the delay.
- R11: stop_req while in STOPPED or RECOVERY is ignored and has no effect on the mode or the recovery length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset, highest-priority exit from stop |
| stop_req | input | 1 | One-cycle request from the CPU to enter stop |
| cfg_short_rec | input | 1 | 1 selects the short recovery delay |
| cfg_keep_fast | input | 1 | 1 keeps the quadruple-rate clock enable high during stop |
| wake_irq | input | NUM_WAKE_SRC | Module interrupt requests, any bit wakes |
| wake_brk | input | 1 | Break request, wakes |
| bus2x_en | output | 1 | Enable of the double-rate bus clock |
| bus4x_en | output | 1 | Enable of the quadruple-rate bus clock |
| stack_go | output | 1 | One-cycle strobe: interrupt stacking may start |
| mode_o | output | 2 | Current mode: 00 RUN, 01 STOPPED, 10 RECOVERY |

## Verification
The hardest situation to reach from the ports is a disturbance partway through a long recovery. Examples are a configuration change or a second wake that might restart the delay, or a reset arriving deep inside the 4096-cycle window. The bench reaches these by counting reference cycles after the wake edge and injecting the disturbance at a chosen count. It then measures the time spent in RECOVERY from the mode output and compares it against the delay captured at entry. A long stop before the wake is used to show that the counter does not advance while stopped.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_STOP = 2'b01,
        MODE_REC  = 2'b10
    } stop_mode_e;

    typedef struct packed {
        stop_mode_e mode;
        logic       short_lat;
        logic       keep_lat;
        logic       stack_go;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{
        mode:      MODE_RUN,
        short_lat: 1'b0,
        keep_lat:  1'b0,
        stack_go:  1'b0
    };

endpackage

// File: rtl/stop_wake_merge.sv
module stop_wake_merge #(
    parameter int NUM_WAKE_SRC = 4
) (
    input  logic [NUM_WAKE_SRC-1:0] irq_i,
    input  logic                    brk_i,
    output logic                    wake_o
);
    logic [NUM_WAKE_SRC:0] chain;

    assign chain[0] = brk_i;

    for (genvar g = 0; g < NUM_WAKE_SRC; g++) begin : g_or
        assign chain[g+1] = chain[g] | irq_i[g];
    end

    assign wake_o = chain[NUM_WAKE_SRC];
endmodule

// File: rtl/stop_rec_timer.sv
module stop_rec_timer #(
    parameter int LONG_CYC  = 4096,
    parameter int SHORT_CYC = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic short_i,
    output logic done_o
);
    localparam int CW = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_CYC - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last   = short_i ? SHORT_LAST : LONG_LAST;
        done_o = !hold_i && (cnt_q == last);
        if (hold_i || done_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/stop_clk_enable.sv
module stop_clk_enable
    import stop_seq_pkg::*;
(
    input  stop_mode_e mode_i,
    input  logic       keep_i,
    output logic       en2x_o,
    output logic       en4x_o
);
    always_comb begin
        en2x_o = (mode_i == MODE_RUN);
        en4x_o = (mode_i == MODE_RUN) || keep_i;
    end
endmodule

// File: rtl/stop_seq_ctrl.sv
module stop_seq_ctrl
    import stop_seq_pkg::*;
#(
    parameter int NUM_WAKE_SRC = 4,
    parameter int LONG_CYC     = 4096,
    parameter int SHORT_CYC    = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    stop_req,
    input  logic                    cfg_short_rec,
    input  logic                    cfg_keep_fast,
    input  logic [NUM_WAKE_SRC-1:0] wake_irq,
    input  logic                    wake_brk,
    output logic                    bus2x_en,
    output logic                    bus4x_en,
    output logic                    stack_go,
    output logic [1:0]              mode_o
);
    ctrl_state_t st_d, st_q;
    logic        wake;
    logic        rec_done;
    logic        timer_hold;

    stop_wake_merge #(
        .NUM_WAKE_SRC(NUM_WAKE_SRC)
    ) wake_i (
        .irq_i  (wake_irq),
        .brk_i  (wake_brk),
        .wake_o (wake)
    );

    assign timer_hold = (st_q.mode != MODE_REC);

    stop_rec_timer #(
        .LONG_CYC (LONG_CYC),
        .SHORT_CYC(SHORT_CYC)
    ) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (timer_hold),
        .short_i(st_q.short_lat),
        .done_o (rec_done)
    );

    stop_clk_enable clken_i (
        .mode_i(st_q.mode),
        .keep_i(st_q.keep_lat),
        .en2x_o(bus2x_en),
        .en4x_o(bus4x_en)
    );

    always_comb begin
        st_d          = st_q;
        st_d.stack_go = 1'b0;
        unique case (st_q.mode)
            MODE_RUN: begin
                if (stop_req) begin
                    st_d.mode      = MODE_STOP;
                    st_d.short_lat = cfg_short_rec;
                    st_d.keep_lat  = cfg_keep_fast;
                end
            end
            MODE_STOP: begin
                if (wake) begin
                    st_d.mode = MODE_REC;
                end
            end
            MODE_REC: begin
                if (rec_done) begin
                    st_d.mode      = MODE_RUN;
                    st_d.stack_go  = 1'b1;
                    st_d.keep_lat  = 1'b0;
                end
            end
            default: begin
                st_d = CTRL_RESET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CTRL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign stack_go = st_q.stack_go;
    assign mode_o   = st_q.mode;
endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk #(
    parameter int NUM_WAKE_SRC = 4,
    parameter int LONG_CYC     = 4096,
    parameter int SHORT_CYC    = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stop_req,
    input logic                    cfg_short_rec,
    input logic                    cfg_keep_fast,
    input logic [NUM_WAKE_SRC-1:0] wake_irq,
    input logic                    wake_brk,
    input logic                    bus2x_en,
    input logic                    bus4x_en,
    input logic                    stack_go,
    input logic [1:0]              mode_o
);
    localparam logic [1:0] M_RUN  = 2'b00;
    localparam logic [1:0] M_STOP = 2'b01;
    localparam logic [1:0] M_REC  = 2'b10;

    logic        any_wake;
    logic        short_seen_q;
    logic        keep_seen_q;
    logic [15:0] rec_cnt_q;
    logic [15:0] rec_expect;

    assign any_wake   = (|wake_irq) || wake_brk;
    assign rec_expect = short_seen_q ? 16'(SHORT_CYC) : 16'(LONG_CYC);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_seen_q <= 1'b0;
            keep_seen_q  <= 1'b0;
            rec_cnt_q    <= '0;
        end else begin
            if (mode_o == M_RUN && stop_req) begin
                short_seen_q <= cfg_short_rec;
                keep_seen_q  <= cfg_keep_fast;
            end
            rec_cnt_q <= (mode_o == M_REC) ? rec_cnt_q + 16'd1 : 16'd0;
        end
    end

    AST_RUN_CLOCKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_RUN |-> bus2x_en && bus4x_en); // R1
    AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_RUN && stop_req |=> mode_o == M_STOP && !bus2x_en); // R2
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_STOP && !any_wake |=> mode_o == M_STOP); // R3
    AST_WAKE_TO_REC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_STOP && any_wake |=> mode_o == M_REC); // R4
    AST_REC_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_RUN && $past(mode_o) == M_REC |-> rec_cnt_q == rec_expect); // R5
    AST_LOWPWR_2X_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != M_RUN |-> !bus2x_en); // R5
    AST_STACK_AFTER_REC: assert property (@(posedge clk) disable iff (!rst_n)
        stack_go |-> mode_o == M_RUN && $past(mode_o) == M_REC); // R6
    AST_STACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stack_go |=> !stack_go); // R6
    AST_KEEP_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != M_RUN |-> bus4x_en == keep_seen_q); // R7
    AST_REC_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == M_REC |=> mode_o != M_STOP); // R10
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'b11); // R11
endmodule

bind stop_seq_ctrl stop_seq_chk #(
    .NUM_WAKE_SRC(NUM_WAKE_SRC),
    .LONG_CYC    (LONG_CYC),
    .SHORT_CYC   (SHORT_CYC)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .cfg_short_rec(cfg_short_rec),
    .cfg_keep_fast(cfg_keep_fast),
    .wake_irq     (wake_irq),
    .wake_brk     (wake_brk),
    .bus2x_en     (bus2x_en),
    .bus4x_en     (bus4x_en),
    .stack_go     (stack_go),
    .mode_o       (mode_o)
);

// File: tb/stop_seq_ctrl_tb_top.sv
module stop_seq_ctrl_tb_top;
    localparam int NSRC  = 4;
    localparam int LONGD = 4096;
    localparam int SHORTD = 32;
    localparam int NVEC  = 6;

    // vector: [15] short, [14] keep, [13:11] source (0..3 irq bit, 4 break), [7:0] stop length
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd0, 3'd0, 8'd3},
        {1'b1, 1'b1, 3'd4, 3'd0, 8'd1},
        {1'b0, 1'b0, 3'd2, 3'd0, 8'd200},
        {1'b1, 1'b0, 3'd3, 3'd0, 8'd250},
        {1'b0, 1'b1, 3'd1, 3'd0, 8'd5},
        {1'b1, 1'b1, 3'd4, 3'd0, 8'd17}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            stop_req = 1'b0;
    logic            cfg_short_rec = 1'b0;
    logic            cfg_keep_fast = 1'b0;
    logic [NSRC-1:0] wake_irq = '0;
    logic            wake_brk = 1'b0;
    logic            bus2x_en, bus4x_en, stack_go;
    logic [1:0]      mode_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    stop_seq_ctrl #(.NUM_WAKE_SRC(NSRC), .LONG_CYC(LONGD), .SHORT_CYC(SHORTD)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req),
        .cfg_short_rec(cfg_short_rec), .cfg_keep_fast(cfg_keep_fast),
        .wake_irq(wake_irq), .wake_brk(wake_brk),
        .bus2x_en(bus2x_en), .bus4x_en(bus4x_en),
        .stack_go(stack_go), .mode_o(mode_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic pulse_wake(input int src);
        if (src >= NSRC) wake_brk = 1'b1;
        else wake_irq[src] = 1'b1;
        @(negedge clk);
        wake_brk = 1'b0;
        wake_irq = '0;
    endtask

    task automatic enter_stop(input bit sh, input bit kp);
        cfg_short_rec = sh;
        cfg_keep_fast = kp;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R2 mode after stop_req", mode_o, 1);
        check("R2 bus2x_en off", bus2x_en, 0);
        check("R7 bus4x_en in stop", bus4x_en, kp);
    endtask

    // counts RECOVERY cycles; disturb_at>0 applies the disturbance at that count
    task automatic measure_rec(output int n, input int disturb_at, input int kind);
        n = 0;
        while (mode_o == 2'b10 && n < LONGD + 100) begin
            n++;
            if (n == disturb_at) begin
                if (kind == 0) begin cfg_short_rec = ~cfg_short_rec; cfg_keep_fast = ~cfg_keep_fast; end
                else if (kind == 1) begin wake_irq = '1; wake_brk = 1'b1; end
                else stop_req = 1'b1;
            end
            @(negedge clk);
            wake_irq = '0;
            wake_brk = 1'b0;
            stop_req = 1'b0;
        end
    endtask

    task automatic finish_check(input int n, input int exp, input string tag);
        check({tag, " recovery length"}, n, exp);
        check("R6 stack_go on return", stack_go, 1);
        check("R6 bus2x_en back on", bus2x_en, 1);
        check("R6 bus4x_en back on", bus4x_en, 1);
        @(negedge clk);
        check("R6 stack_go single pulse", stack_go, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset mode", mode_o, 0);
        check("R1 reset bus2x_en", bus2x_en, 1);
        check("R1 reset bus4x_en", bus4x_en, 1);
        check("R1 reset stack_go", stack_go, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            enter_stop(v[15], v[14]);
            repeat (int'(v[7:0])) @(negedge clk);
            check("R3 still stopped", mode_o, 1);
            check("R7 bus4x_en during stop", bus4x_en, v[14]);
            pulse_wake(int'(v[13:11]));
            check("R4 mode after wake", mode_o, 2);
            check("R5 bus2x_en off in recovery", bus2x_en, 0);
            check("R7 bus4x_en in recovery", bus4x_en, v[14]);
            measure_rec(n, 0, 0);
            finish_check(n, v[15] ? SHORTD : LONGD, "R5 R3");
        end

        // R9: config flipped during stop and recovery has no effect
        enter_stop(1'b1, 1'b0);
        cfg_short_rec = 1'b0; cfg_keep_fast = 1'b1;
        @(negedge clk);
        check("R9 bus4x_en ignores cfg change", bus4x_en, 0);
        pulse_wake(0);
        measure_rec(n, 10, 0);
        finish_check(n, SHORTD, "R9");

        // R10: wakes during recovery ignored
        enter_stop(1'b1, 1'b0);
        pulse_wake(4);
        measure_rec(n, 20, 1);
        finish_check(n, SHORTD, "R10");

        // R11: stop_req in STOPPED and RECOVERY ignored
        enter_stop(1'b1, 1'b0);
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R11 stop_req in stop", mode_o, 1);
        pulse_wake(1);
        measure_rec(n, 15, 2);
        finish_check(n, SHORTD, "R11");

        // R8: reset deep inside a long recovery, wake held active
        enter_stop(1'b0, 1'b1);
        pulse_wake(2);
        repeat (1000) @(negedge clk);
        check("R8 still recovering", mode_o, 2);
        wake_brk = 1'b1;
        rst_n = 1'b0;
        #1;
        check("R8 async reset mode", mode_o, 0);
        check("R8 async reset bus2x_en", bus2x_en, 1);
        check("R8 async reset bus4x_en", bus4x_en, 1);
        check("R8 async reset stack_go", stack_go, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wake_brk = 1'b0;
        check("R8 stays in run after reset", mode_o, 0);

        // R8: reset while stopped
        enter_stop(1'b1, 1'b0);
        rst_n = 1'b0;
        #1;
        check("R8 reset from stop", mode_o, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 run after stop reset", bus2x_en, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule